// File: doc/BRIEF.md
# Octant Vector Line Drawer

This engine draws a straight line into a 256 x 256 bitmap that is stored as several bit-per-pixel planes packed side by side. A controller pulses `start` and presents, in the same cycle, the octant, a slope/length word, the start coordinate and one pattern byte for each plane. The engine then walks the line one pixel at a time. For each pixel it reads the two adjacent bitmap bytes that the pixel may cover, XORs the pattern (shifted by the pixel's bit offset) into every plane, writes both bytes back, and moves one step.

The step uses an accumulator of coordinate width that starts at its midpoint. Each step adds the slope byte, and the carry out picks one of two moves: the major-axis move or the diagonal move of the chosen octant. The length is a start value for an up-counter that ends when it reaches 256. As an option, the engine detects overlap with pixels that are already lit. It latches the first such pixel until the controller clears the flag. At the end it reports the final X coordinate and echoes a chain flag for a command sequencer.

Top module: `vec_line_engine`

## Requirements
- R1: After reset, `busy`, `done`, `chain_out`, `mem_rd`, `mem_wr` and `coll_flag` are low, and `x_final`, `coll_x` and `coll_y` are zero.
- R2: A `start` pulse while idle is accepted. `busy` then stays high for exactly 3 + 2N cycles, where N = 256 - `step_word[7:0]` (a low byte of 0 gives 256 pixels). A `start` pulse while busy is ignored and changes neither the timing nor the pixels drawn.
- R3: Counting the cycles after the accepting clock edge from 0, pixel k is read in cycle 2+2k (`mem_rd`) and written in cycle 3+2k (`mem_wr`). In both cycles `mem_addr0` = Y*32 + X/8 and `mem_addr1` = `mem_addr0` + 1 modulo 8192.
- R4: Plane p occupies bits [8p+7:8p] of the pattern and of the data buses (blue p=0, green p=1, red p=2). With s = X mod 8, the near byte is XORed with pattern>>s and the far byte with (pattern<<(8-s)) mod 256, and all planes are written.
- R5: The accumulator is set to 128 at the start of a line. After each pixel, `step_word[15:8]` is added. A carry out of 8 bits selects the diagonal move, no carry selects the major move, and the accumulator keeps the low 8 bits.
- R6: Moves as (dx,dy) without carry / with carry, by `octant`: 0 (+1,0)/(+1,-1); 1 (0,-1)/(+1,-1); 2 (0,-1)/(-1,-1); 3 (-1,0)/(-1,-1); 4 (-1,0)/(-1,+1); 5 (0,+1)/(-1,+1); 6 (0,+1)/(+1,+1); 7 (+1,0)/(+1,+1).
- R7: A pixel is plotted before the step. X and Y wrap modulo 256.
- R8: When `detect_en` was set at start and `coll_flag` is low, a pixel whose shifted pattern ANDed with the read data is nonzero in any plane sets `coll_flag` and latches that pixel's X and Y into `coll_x`/`coll_y`. While the flag is set, later overlaps change nothing.
- R9: `coll_clr` clears `coll_flag` on the next edge. A collision detected in the same cycle wins.
- R10: In the last busy cycle `done` pulses for one cycle with `chain_out` equal to the `chain_in` value captured at start. From the next cycle on, `x_final` holds the X reached after the last step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a line (accepted only when idle) |
| octant | input | 3 | Octant select |
| detect_en | input | 1 | Enable overlap detection for this line |
| chain_in | input | 1 | Continue flag to echo at completion |
| step_word | input | 16 | [15:8] slope increment, [7:0] counter start |
| x_start | input | 8 | Start X |
| y_start | input | 8 | Start Y |
| pattern | input | 24 | Pattern bytes, one per plane |
| coll_clr | input | 1 | Clear the collision flag |
| busy | output | 1 | Line in progress |
| done | output | 1 | One-cycle completion pulse |
| chain_out | output | 1 | Echoed continue flag, valid with done |
| x_final | output | 8 | X after the last step |
| mem_rd | output | 1 | Read both bytes this cycle |
| mem_wr | output | 1 | Write both bytes this cycle |
| mem_addr0 | output | 13 | Near byte address |
| mem_addr1 | output | 13 | Far byte address |
| mem_rdata0 | input | 24 | Near byte data, one cycle after mem_rd |
| mem_rdata1 | input | 24 | Far byte data, one cycle after mem_rd |
| mem_wdata0 | output | 24 | Near byte write data |
| mem_wdata1 | output | 24 | Far byte write data |
| coll_flag | output | 1 | Collision latched |
| coll_x | output | 8 | X of the latched collision |
| coll_y | output | 8 | Y of the latched collision |

## Verification
Counting from the clock edge that accepts `start`, `busy` rises in cycle 0. The read of pixel k comes in cycle 2+2k and its write, carrying the XORed data, in cycle 3+2k. `done` comes in cycle 2+2N, and `x_final` and the collision registers are valid one cycle after `done`. When `start` is accepted, the reference model builds a queue with one entry per cycle, holding the expected strobes, addresses and write data. One entry is taken and compared at every falling edge, so every due cycle is checked exactly where it is due. Once the queue has drained, the final X, the collision state and the whole bitmap are compared against the model.

// File: rtl/vec_pkg.sv
package vec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_INIT = 3'd1,
    ST_AIM  = 3'd2,
    ST_RD   = 3'd3,
    ST_WR   = 3'd4,
    ST_END  = 3'd5
  } vstate_t;

  // signed unit move per axis
  typedef struct packed {
    logic [1:0] dx;
    logic [1:0] dy;
  } vstep_t;

  localparam logic [1:0] MV_POS  = 2'b01;
  localparam logic [1:0] MV_NEG  = 2'b11;
  localparam logic [1:0] MV_ZERO = 2'b00;

endpackage

// File: rtl/vec_octant_lut.sv
module vec_octant_lut
  import vec_pkg::*;
(
  input  logic [2:0] octant,
  output vstep_t     along,
  output vstep_t     diag
);

  always_comb begin
    case (octant)
      3'd0: begin along = '{MV_POS,  MV_ZERO}; diag = '{MV_POS, MV_NEG}; end
      3'd1: begin along = '{MV_ZERO, MV_NEG};  diag = '{MV_POS, MV_NEG}; end
      3'd2: begin along = '{MV_ZERO, MV_NEG};  diag = '{MV_NEG, MV_NEG}; end
      3'd3: begin along = '{MV_NEG,  MV_ZERO}; diag = '{MV_NEG, MV_NEG}; end
      3'd4: begin along = '{MV_NEG,  MV_ZERO}; diag = '{MV_NEG, MV_POS}; end
      3'd5: begin along = '{MV_ZERO, MV_POS};  diag = '{MV_NEG, MV_POS}; end
      3'd6: begin along = '{MV_ZERO, MV_POS};  diag = '{MV_POS, MV_POS}; end
      default: begin along = '{MV_POS, MV_ZERO}; diag = '{MV_POS, MV_POS}; end
    endcase
  end

endmodule

// File: rtl/vec_stepper.sv
module vec_stepper
  import vec_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x_cur,
  input  logic [W-1:0] y_cur,
  input  logic [W-1:0] acc_cur,
  input  logic [W-1:0] slope,
  input  vstep_t       along,
  input  vstep_t       diag,
  output logic [W-1:0] x_nxt,
  output logic [W-1:0] y_nxt,
  output logic [W-1:0] acc_nxt
);

  logic [W:0] sum;
  vstep_t     mv;

  always_comb begin
    sum     = {1'b0, acc_cur} + {1'b0, slope};
    mv      = sum[W] ? diag : along;
    acc_nxt = sum[W-1:0];
    x_nxt   = x_cur + {{(W-2){mv.dx[1]}}, mv.dx};
    y_nxt   = y_cur + {{(W-2){mv.dy[1]}}, mv.dy};
  end

endmodule

// File: rtl/vec_plane_rmw.sv
module vec_plane_rmw #(
  parameter  int BW   = 8,
  localparam int SH_W = $clog2(BW)
) (
  input  logic [BW-1:0]   pat,
  input  logic [SH_W-1:0] sh,
  input  logic [BW-1:0]   old_near,
  input  logic [BW-1:0]   old_far,
  output logic [BW-1:0]   new_near,
  output logic [BW-1:0]   new_far,
  output logic            hit
);

  logic [2*BW-1:0] span;

  always_comb begin
    span     = {pat, {BW{1'b0}}} >> sh;
    new_near = old_near ^ span[2*BW-1:BW];
    new_far  = old_far  ^ span[BW-1:0];
    hit      = |((old_near & span[2*BW-1:BW]) | (old_far & span[BW-1:0]));
  end

endmodule

// File: rtl/vec_line_engine.sv
module vec_line_engine
  import vec_pkg::*;
#(
  parameter  int COORD_W = 8,
  parameter  int BYTE_W  = 8,
  parameter  int PLANES  = 3,
  localparam int SH_W    = $clog2(BYTE_W),
  localparam int ADDR_W  = 2 * COORD_W - SH_W,
  localparam int DATA_W  = PLANES * BYTE_W,
  localparam int CNT_W   = COORD_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [2:0]           octant,
  input  logic                 detect_en,
  input  logic                 chain_in,
  input  logic [2*COORD_W-1:0] step_word,
  input  logic [COORD_W-1:0]   x_start,
  input  logic [COORD_W-1:0]   y_start,
  input  logic [DATA_W-1:0]    pattern,
  input  logic                 coll_clr,
  output logic                 busy,
  output logic                 done,
  output logic                 chain_out,
  output logic [COORD_W-1:0]   x_final,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [ADDR_W-1:0]    mem_addr0,
  output logic [ADDR_W-1:0]    mem_addr1,
  input  logic [DATA_W-1:0]    mem_rdata0,
  input  logic [DATA_W-1:0]    mem_rdata1,
  output logic [DATA_W-1:0]    mem_wdata0,
  output logic [DATA_W-1:0]    mem_wdata1,
  output logic                 coll_flag,
  output logic [COORD_W-1:0]   coll_x,
  output logic [COORD_W-1:0]   coll_y
);

  localparam logic [COORD_W-1:0] ACC_MID = {1'b1, {(COORD_W-1){1'b0}}};

  // registers and their next values
  vstate_t              st_q,    st_n;
  logic [2:0]           oct_q,   oct_n;
  logic                 det_q,   det_n;
  logic                 chn_q,   chn_n;
  logic [COORD_W-1:0]   slope_q, slope_n;
  logic [CNT_W-1:0]     cnt_q,   cnt_n;
  logic [COORD_W-1:0]   x_q,     x_n;
  logic [COORD_W-1:0]   y_q,     y_n;
  logic [COORD_W-1:0]   acc_q,   acc_n;
  logic [DATA_W-1:0]    pat_q,   pat_n;
  logic                 coll_q,  coll_n;
  logic [COORD_W-1:0]   cx_q,    cx_n;
  logic [COORD_W-1:0]   cy_q,    cy_n;
  logic [COORD_W-1:0]   xfin_q,  xfin_n;

  vstep_t             mv_along, mv_diag;
  logic [COORD_W-1:0] x_step, y_step, acc_step;
  logic [PLANES-1:0]  hit_vec;
  logic               any_hit;

  vec_octant_lut u_lut (
    .octant (oct_q),
    .along  (mv_along),
    .diag   (mv_diag)
  );

  vec_stepper #(.W(COORD_W)) u_step (
    .x_cur   (x_q),
    .y_cur   (y_q),
    .acc_cur (acc_q),
    .slope   (slope_q),
    .along   (mv_along),
    .diag    (mv_diag),
    .x_nxt   (x_step),
    .y_nxt   (y_step),
    .acc_nxt (acc_step)
  );

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    vec_plane_rmw #(.BW(BYTE_W)) u_rmw (
      .pat      (pat_q[p*BYTE_W +: BYTE_W]),
      .sh       (x_q[SH_W-1:0]),
      .old_near (mem_rdata0[p*BYTE_W +: BYTE_W]),
      .old_far  (mem_rdata1[p*BYTE_W +: BYTE_W]),
      .new_near (mem_wdata0[p*BYTE_W +: BYTE_W]),
      .new_far  (mem_wdata1[p*BYTE_W +: BYTE_W]),
      .hit      (hit_vec[p])
    );
  end

  assign any_hit = |hit_vec;

  // next-state logic
  always_comb begin
    st_n    = st_q;
    oct_n   = oct_q;
    det_n   = det_q;
    chn_n   = chn_q;
    slope_n = slope_q;
    cnt_n   = cnt_q;
    x_n     = x_q;
    y_n     = y_q;
    acc_n   = acc_q;
    pat_n   = pat_q;
    xfin_n  = xfin_q;
    coll_n  = coll_q;
    cx_n    = cx_q;
    cy_n    = cy_q;

    case (st_q)
      ST_IDLE: begin
        if (start) begin
          oct_n   = octant;
          det_n   = detect_en;
          chn_n   = chain_in;
          slope_n = step_word[2*COORD_W-1:COORD_W];
          cnt_n   = {1'b0, step_word[COORD_W-1:0]};
          x_n     = x_start;
          y_n     = y_start;
          pat_n   = pattern;
          st_n    = ST_INIT;
        end
      end
      ST_INIT: begin
        acc_n = ACC_MID;
        st_n  = ST_AIM;
      end
      ST_AIM: st_n = ST_RD;
      ST_RD:  st_n = ST_WR;
      ST_WR: begin
        x_n   = x_step;
        y_n   = y_step;
        acc_n = acc_step;
        cnt_n = cnt_q + CNT_W'(1);
        st_n  = cnt_n[CNT_W-1] ? ST_END : ST_RD;
      end
      ST_END: begin
        xfin_n = x_q;
        st_n   = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase

    if (coll_clr) coll_n = 1'b0;
    if (st_q == ST_WR && det_q && !coll_q && any_hit) begin
      coll_n = 1'b1;
      cx_n   = x_q;
      cy_n   = y_q;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      oct_q   <= '0;
      det_q   <= 1'b0;
      chn_q   <= 1'b0;
      slope_q <= '0;
      cnt_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
      acc_q   <= '0;
      pat_q   <= '0;
      xfin_q  <= '0;
      coll_q  <= 1'b0;
      cx_q    <= '0;
      cy_q    <= '0;
    end else begin
      st_q    <= st_n;
      oct_q   <= oct_n;
      det_q   <= det_n;
      chn_q   <= chn_n;
      slope_q <= slope_n;
      cnt_q   <= cnt_n;
      x_q     <= x_n;
      y_q     <= y_n;
      acc_q   <= acc_n;
      pat_q   <= pat_n;
      xfin_q  <= xfin_n;
      coll_q  <= coll_n;
      cx_q    <= cx_n;
      cy_q    <= cy_n;
    end
  end

  // outputs
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_END);
  assign chain_out = done & chn_q;
  assign x_final   = xfin_q;
  assign mem_rd    = (st_q == ST_RD);
  assign mem_wr    = (st_q == ST_WR);
  assign mem_addr0 = {y_q, x_q[COORD_W-1:SH_W]};
  assign mem_addr1 = mem_addr0 + ADDR_W'(1);
  assign coll_flag = coll_q;
  assign coll_x    = cx_q;
  assign coll_y    = cy_q;

endmodule

// File: rtl/vec_line_checker.sv
module vec_line_checker #(
  parameter  int COORD_W = 8,
  parameter  int BYTE_W  = 8,
  localparam int ADDR_W  = 2 * COORD_W - $clog2(BYTE_W)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               mem_rd,
  input logic               mem_wr,
  input logic [ADDR_W-1:0]  mem_addr0,
  input logic               coll_flag,
  input logic               coll_clr,
  input logic [COORD_W-1:0] coll_x,
  input logic [COORD_W-1:0] coll_y
);

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R3
  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> $past(mem_rd)); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> mem_addr0 == $past(mem_addr0)); // R3
  AST_RD_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd || mem_wr) |-> busy); // R3
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R2
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(done)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_COLL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_flag && !coll_clr) |=> (coll_flag && $stable(coll_x) && $stable(coll_y))); // R8
  AST_COLL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (coll_clr && !mem_wr) |=> !coll_flag); // R9

endmodule

bind vec_line_engine vec_line_checker #(.COORD_W(COORD_W), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_addr0 (mem_addr0),
  .coll_flag (coll_flag),
  .coll_clr  (coll_clr),
  .coll_x    (coll_x),
  .coll_y    (coll_y)
);

// File: tb/sim_vec_line_engine.sv
`timescale 1ns/1ps
module sim_vec_line_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  octant;
  logic        detect_en;
  logic        chain_in;
  logic [15:0] step_word;
  logic [7:0]  x_start, y_start;
  logic [23:0] pattern;
  logic        coll_clr;
  logic        busy, done, chain_out;
  logic [7:0]  x_final;
  logic        mem_rd, mem_wr;
  logic [12:0] mem_addr0, mem_addr1;
  logic [23:0] mem_rdata0, mem_rdata1, mem_wdata0, mem_wdata1;
  logic        coll_flag;
  logic [7:0]  coll_x, coll_y;

  int checks = 0;
  int errors = 0;
  bit wd_hit = 0;

  always #10 clk = ~clk;

  vec_line_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .octant(octant),
    .detect_en(detect_en), .chain_in(chain_in), .step_word(step_word),
    .x_start(x_start), .y_start(y_start), .pattern(pattern),
    .coll_clr(coll_clr), .busy(busy), .done(done), .chain_out(chain_out),
    .x_final(x_final), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr0(mem_addr0), .mem_addr1(mem_addr1),
    .mem_rdata0(mem_rdata0), .mem_rdata1(mem_rdata1),
    .mem_wdata0(mem_wdata0), .mem_wdata1(mem_wdata1),
    .coll_flag(coll_flag), .coll_x(coll_x), .coll_y(coll_y)
  );

  // bitmap held by the bench, synchronous read
  logic [23:0] bmem [int];
  logic [23:0] mmem [int];

  function automatic logic [23:0] bread(int a);
    return bmem.exists(a) ? bmem[a] : 24'h0;
  endfunction

  function automatic logic [23:0] mread(int a);
    return mmem.exists(a) ? mmem[a] : 24'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata0 <= bread(int'(mem_addr0));
      mem_rdata1 <= bread(int'(mem_addr1));
    end
    if (mem_wr) begin
      bmem[int'(mem_addr0)] = mem_wdata0;
      bmem[int'(mem_addr1)] = mem_wdata1;
    end
  end

  task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  // reference model state
  int q_busy[$], q_rd[$], q_wr[$], q_done[$], q_addr[$], q_wd0[$], q_wd1[$], q_chn[$];
  bit m_coll = 0;
  int m_cx = 0, m_cy = 0, m_xf = 0;
  int tdx[8]  = '{1, 0, 0, -1, -1, 0, 0, 1};
  int tdy[8]  = '{0, -1, -1, 0, 0, 1, 1, 0};
  int tdxc[8] = '{1, 1, -1, -1, -1, -1, 1, 1};
  int tdyc[8] = '{-1, -1, -1, -1, 1, 1, 1, 1};

  task automatic push_cyc(int b, int r, int w, int d, int a, int w0, int w1, int c);
    q_busy.push_back(b); q_rd.push_back(r); q_wr.push_back(w); q_done.push_back(d);
    q_addr.push_back(a); q_wd0.push_back(w0); q_wd1.push_back(w1); q_chn.push_back(c);
  endtask

  task automatic model_line(input int o, input bit det, input bit chn, input logic [15:0] w,
                            input int xs, input int ys, input logic [23:0] pat);
    int x = xs, y = ys, acc = 128, n, s, a, a1;
    logic [23:0] o0, o1, m0, m1;
    n = 256 - int'(w[7:0]);
    push_cyc(1, 0, 0, 0, 0, 0, 0, 0);
    push_cyc(1, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < n; k++) begin
      a  = y * 32 + x / 8;
      a1 = (a + 1) % 8192;
      s  = x % 8;
      o0 = mread(a);
      o1 = mread(a1);
      m0 = '0; m1 = '0;
      for (int p = 0; p < 3; p++) begin
        m0[p*8 +: 8] = 8'(int'(pat[p*8 +: 8]) >> s);
        m1[p*8 +: 8] = 8'((int'(pat[p*8 +: 8]) << (8 - s)) & 255);
      end
      if (det && !m_coll && (((o0 & m0) | (o1 & m1)) != 0)) begin
        m_coll = 1; m_cx = x; m_cy = y;
      end
      mmem[a]  = o0 ^ m0;
      mmem[a1] = o1 ^ m1;
      push_cyc(1, 1, 0, 0, a, 0, 0, 0);
      push_cyc(1, 0, 1, 0, a, int'(o0 ^ m0), int'(o1 ^ m1), 0);
      acc = acc + int'(w[15:8]);
      if (acc >= 256) begin
        acc -= 256;
        x = (x + tdxc[o] + 256) % 256;
        y = (y + tdyc[o] + 256) % 256;
      end else begin
        x = (x + tdx[o] + 256) % 256;
        y = (y + tdy[o] + 256) % 256;
      end
    end
    push_cyc(1, 0, 0, 1, 0, 0, 0, int'(chn));
    m_xf = x;
  endtask

  // cycle-by-cycle comparison against the model queue
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !wd_hit) begin
      if (q_busy.size() > 0) begin
        int eb, er, ew, ed, ea, e0, e1, ec;
        bit ok;
        eb = q_busy.pop_front(); er = q_rd.pop_front(); ew = q_wr.pop_front();
        ed = q_done.pop_front(); ea = q_addr.pop_front(); e0 = q_wd0.pop_front();
        e1 = q_wd1.pop_front(); ec = q_chn.pop_front();
        ok = (busy == eb[0]) && (mem_rd == er[0]) && (mem_wr == ew[0]) && (done == ed[0]);
        chk(ok, "R2 R3 R10 strobes busy/rd/wr/done", {busy, mem_rd, mem_wr, done},
            {eb[0], er[0], ew[0], ed[0]});
        if (er != 0 || ew != 0)
          chk(mem_addr0 == 13'(ea) && mem_addr1 == 13'((ea + 1) % 8192),
              "R3 R5 R6 R7 pixel address", {mem_addr0, mem_addr1}, {13'(ea), 13'((ea + 1) % 8192)});
        if (ew != 0)
          chk(mem_wdata0 == 24'(e0) && mem_wdata1 == 24'(e1), "R4 write data",
              {mem_wdata0, mem_wdata1}, {24'(e0), 24'(e1)});
        if (ed != 0)
          chk(chain_out == ec[0], "R10 chain_out", chain_out, ec);
      end else begin
        chk(!busy && !mem_rd && !mem_wr && !done, "R2 idle strobes",
            {busy, mem_rd, mem_wr, done}, 0);
      end
    end
  end

  task automatic wait_idle();
    while (1) begin
      @(negedge clk); #1;
      if (q_busy.size() == 0) break;
    end
    @(negedge clk); #1;
  endtask

  task automatic final_checks(input string tag);
    int bad = 0;
    chk(x_final == 8'(m_xf), {"R10 x_final ", tag}, x_final, m_xf);
    chk(coll_flag == m_coll, {"R8 coll_flag ", tag}, coll_flag, m_coll);
    if (m_coll)
      chk(coll_x == 8'(m_cx) && coll_y == 8'(m_cy), {"R8 collision pixel ", tag},
          {coll_x, coll_y}, {8'(m_cx), 8'(m_cy)});
    foreach (mmem[k]) if (bread(k) != mmem[k]) bad++;
    foreach (bmem[k]) if (bmem[k] != mread(k)) bad++;
    chk(bad == 0, {"R4 R7 bitmap contents ", tag}, bad, 0);
  endtask

  task automatic run_line(input int o, input bit det, input bit chn, input logic [15:0] w,
                          input int xs, input int ys, input logic [23:0] pat,
                          input int poke, input string tag);
    @(posedge clk); #2;
    octant = 3'(o); detect_en = det; chain_in = chn; step_word = w;
    x_start = 8'(xs); y_start = 8'(ys); pattern = pat; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    model_line(o, det, chn, w, xs, ys, pat);
    if (poke > 0) begin
      // R2: a start while busy must be ignored
      repeat (poke) @(posedge clk);
      #2;
      octant = 3'(~o); detect_en = 1'b1; step_word = 16'hFF00;
      x_start = 8'(xs + 37); y_start = 8'(ys + 91); pattern = 24'hFFFFFF; start = 1'b1;
      @(posedge clk); #2;
      start = 1'b0;
    end
    wait_idle();
    final_checks(tag);
  endtask

  task automatic clear_coll();
    @(posedge clk); #2 coll_clr = 1'b1;
    @(posedge clk); #2 coll_clr = 1'b0;
    m_coll = 0;
    @(negedge clk); #1;
    chk(coll_flag == 1'b0, "R9 coll_clr clears flag", coll_flag, 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    wd_hit = 1;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; octant = '0; detect_en = 1'b0; chain_in = 1'b0;
    step_word = '0; x_start = '0; y_start = '0; pattern = '0; coll_clr = 1'b0;
    mem_rdata0 = '0; mem_rdata1 = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(!busy && !done && !chain_out && !mem_rd && !mem_wr && !coll_flag, "R1 reset strobes",
        {busy, done, chain_out, mem_rd, mem_wr, coll_flag}, 0);
    chk(x_final == 0 && coll_x == 0 && coll_y == 0, "R1 reset values",
        {x_final, coll_x, coll_y}, 0);

    // short line, mixed pattern, chain set
    run_line(0, 0, 1, 16'h40F8, 10, 20, 24'hC381FF, 0, "short oct0");
    // R6: every octant
    for (int o = 0; o < 8; o++)
      run_line(o, 0, o[0], 16'h55F0, 100, 100, 24'h01803C, 0, "octant sweep");
    // R7: coordinate wrap downwards
    run_line(2, 0, 0, 16'h30FA, 1, 2, 24'hFFFFFF, 0, "wrap low");
    // R3: far byte address wraps past the last byte
    run_line(7, 0, 1, 16'h00FC, 250, 255, 24'hA55A0F, 0, "addr wrap");
    // byte-aligned X (shift 0), steep slope
    run_line(1, 0, 0, 16'h80FC, 16, 50, 24'h8001FE, 0, "aligned");
    // R8: draw, then redraw with detection to collide
    run_line(6, 0, 0, 16'h20F4, 40, 200, 24'h00F000, 0, "coll base");
    run_line(6, 1, 0, 16'h20F4, 40, 200, 24'h00F000, 0, "coll hit");
    run_line(6, 1, 0, 16'h20F6, 41, 201, 24'h00FF00, 0, "coll held");
    // R9
    clear_coll();
    run_line(6, 1, 1, 16'h20F8, 40, 200, 24'h000011, 0, "coll again");
    clear_coll();
    // R2: long line (256 pixels) with a start pulse while busy
    run_line(5, 0, 1, 16'hFF00, 128, 0, 24'h000001, 30, "full length");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule